// File: doc/BRIEF.md
# Serial Register-Access Slave with Per-Address Frame Length

This block is the serial slave port of a multi-channel converter's register file. A host opens a frame by pulling the active-low select low. It clocks in one command byte that carries a direction flag and a 7-bit register address. After that comes a data phase whose length in bytes is looked up from the address. Reads shift a frozen copy of the addressed register out on the serial output. Writes are collected and applied to the register only on the final rising clock edge of a complete frame, so a frame that is cut short leaves every register untouched.

The serial pins (`cs_n`, `sclk`, `din`) are asynchronous to `clk`. They are oversampled through a two-stage synchronizer, and their edges are detected in the `clk` domain, so `sclk` must stay in each level for at least four `clk` cycles. The block holds a 96-bit conversion-result register, made of four 24-bit channels, plus three writable configuration registers, and it drives a data-ready indication. Conversion results enter as a valid-only stream (`conv_valid`/`conv_data`) with no back-pressure: every beat with `conv_valid` high is accepted in that cycle, and the source never waits. `drdy_in` and `drdy_out` are plain control pins, synchronous to `clk`.

Top module: `spi_regfile_slave`

## Requirements
- R1: The first 8 bits of a frame form the command, sent MSB first. Bit 7 = 1 selects read and 0 selects write; bits 6:0 hold the register address. Data bits also move MSB first.
- R2: `sclk` idles high. `din` is sampled on falling edges of `sclk` and `dout` changes only on rising edges. `dout` is 0 during the command byte, and the first data bit appears on the rising edge that follows the 8th falling edge.
- R3: While `cs_n` is high, `dout_oe` is 0. While a frame is open, `dout_oe` is 1. Both follow `cs_n` within 3 `clk` cycles.
- R4: The data phase is 12 bytes for address 0x00 (result), 1 byte for 0x01 (`cfg_mode`), 2 bytes for 0x02 (`cfg_offset`), 3 bytes for 0x03 (`cfg_phase`) and 1 byte for any other address.
- R5: A write is applied on the last rising `sclk` edge of the frame. If `cs_n` rises before that edge, even after every data bit has been sampled, no register changes.
- R6: A `conv_valid` beat loads `conv_data` into the result register. Channel 0 occupies bits 95:72 and is shifted out first. Serial writes to address 0x00 leave it unchanged.
- R7: A read of the result register returns the value held at the 8th falling edge, even if a conversion arrives during the data phase.
- R8: Unmapped addresses read as 0x00, and writes to them change no register.
- R9: With `drdy_in` low and `drdy_out` high, a `conv_valid` beat drives `drdy_out` low in the next cycle.
- R10: `drdy_out` returns high after a complete read frame of the result register.
- R11: If `drdy_out` is already low when a new `conv_valid` arrives with `drdy_in` low, `drdy_out` goes high for one cycle and then low again.
- R12: While `drdy_in` is high, `drdy_out` is high and conversions are not flagged.
- R13: After reset, all registers read zero, `drdy_out` is high and `dout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low (asynchronous) |
| sclk | input | 1 | Serial clock, idles high (asynchronous) |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for `dout` (0 = high impedance) |
| drdy_in | input | 1 | Data-ready input; low enables flagging |
| drdy_out | output | 1 | Data-ready output, active low |
| conv_valid | input | 1 | Conversion-result beat valid |
| conv_data | input | 96 | Four 24-bit channel results, channel 0 in the MSBs |
| cfg_mode | output | 8 | Register 0x01 |
| cfg_offset | output | 16 | Register 0x02 |
| cfg_phase | output | 24 | Register 0x03 |

## Verification
Reads and writes are run at every data length (1, 2, 3 and 12 bytes) with values whose top bit is set. A wrong length lookup or a `dout` that moves one edge early or late then shows up as a shifted readback. Frames are cut off at two points: mid-data, and after the last falling edge but before the last rising edge. Together these show whether the commit is tied to the final rising edge rather than to bit sampling. A conversion is injected in the middle of a result read, which separates snapshot behaviour from live shifting. Repeated conversions with and without a read in between, plus toggling `drdy_in`, exercise the fall, re-arm pulse, clear and gating paths of the data-ready output.

// File: rtl/spirf_pkg.sv
package spirf_pkg;
  localparam int ADDR_W  = 7;
  localparam int MODE_W  = 8;
  localparam int OFFS_W  = 16;
  localparam int PHASE_W = 24;

  localparam logic [ADDR_W-1:0] A_RESULT = 7'h00;
  localparam logic [ADDR_W-1:0] A_MODE   = 7'h01;
  localparam logic [ADDR_W-1:0] A_OFFSET = 7'h02;
  localparam logic [ADDR_W-1:0] A_PHASE  = 7'h03;

  // Serial pin bundle positions inside the synchronizer vector
  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic din;
  } pins_t;
endpackage

// File: rtl/spirf_sync.sv
module spirf_sync #(
  parameter int STAGES = 2,
  parameter int W = 3,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stg[i] <= INIT;
      else if (i == 0)  stg[i] <= d;
      else              stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spirf_frame.sv
module spirf_frame #(
  parameter int RES_W  = 96,
  parameter int ADDR_W = 7,
  localparam int RES_BYTES = RES_W / 8,
  localparam int LEN_W = $clog2(RES_BYTES + 1),
  localparam int CNT_W = $clog2(8 * RES_BYTES + 9)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              din_s,
  output logic [ADDR_W-1:0] look_addr,
  input  logic [RES_W-1:0]  rd_data,
  input  logic [LEN_W-1:0]  rd_len,
  output logic [ADDR_W-1:0] frm_addr,
  output logic              wr_en,
  output logic [RES_W-1:0]  wr_data,
  output logic              rd_fin,
  output logic              dout,
  output logic              dout_oe
);
  logic              sclk_d, fall, rise, in_cmd;
  logic [CNT_W-1:0]  bit_cnt, total;
  logic              rw_q, done_q, wr_q, rdfin_q, dout_q, oe_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [RES_W-1:0]  in_sh, out_sh;

  assign fall      = sclk_d & ~sclk_s;
  assign rise      = ~sclk_d & sclk_s;
  assign in_cmd    = bit_cnt < CNT_W'(8);
  assign total     = CNT_W'(8) + CNT_W'({len_q, 3'b000});
  assign look_addr = {in_sh[ADDR_W-2:0], din_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b1;
      bit_cnt <= '0;
      rw_q    <= 1'b0;
      addr_q  <= '0;
      len_q   <= '0;
      in_sh   <= '0;
      out_sh  <= '0;
      dout_q  <= 1'b0;
      done_q  <= 1'b0;
      wr_q    <= 1'b0;
      rdfin_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      sclk_d  <= sclk_s;
      wr_q    <= 1'b0;
      rdfin_q <= 1'b0;
      oe_q    <= ~cs_s;
      if (cs_s) begin
        bit_cnt <= '0;
        done_q  <= 1'b0;
        dout_q  <= 1'b0;
      end else if (fall && (in_cmd || bit_cnt < total)) begin
        in_sh   <= {in_sh[RES_W-2:0], din_s};
        bit_cnt <= bit_cnt + CNT_W'(1);
        if (bit_cnt == CNT_W'(7)) begin
          rw_q   <= in_sh[ADDR_W-1];
          addr_q <= look_addr;
          len_q  <= rd_len;
          out_sh <= rd_data;
        end
      end else if (rise && !in_cmd && !done_q) begin
        if (bit_cnt < total) begin
          dout_q <= out_sh[RES_W-1];
          out_sh <= {out_sh[RES_W-2:0], 1'b0};
        end else begin
          done_q  <= 1'b1;
          wr_q    <= ~rw_q;
          rdfin_q <= rw_q;
        end
      end
    end
  end

  assign frm_addr = addr_q;
  assign wr_en    = wr_q;
  assign wr_data  = in_sh;
  assign rd_fin   = rdfin_q;
  assign dout     = dout_q;
  assign dout_oe  = oe_q;

  // R2: output bit never moves on a falling edge
  assert_dout_hold_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !cs_s) |=> $stable(dout_q));
  // R3: deselected interface releases the output
  assert_hiz_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !dout_oe);
  // R5: at most one commit per frame
  assert_single_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q);
endmodule

// File: rtl/spirf_regbank.sv
module spirf_regbank
  import spirf_pkg::*;
#(
  parameter int CH_N = 4,
  parameter int CH_W = 24,
  localparam int RES_W = CH_N * CH_W,
  localparam int RES_BYTES = RES_W / 8,
  localparam int LEN_W = $clog2(RES_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  look_addr,
  output logic [RES_W-1:0]   rd_data,
  output logic [LEN_W-1:0]   rd_len,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [RES_W-1:0]   wr_data,
  input  logic               conv_valid,
  input  logic [RES_W-1:0]   conv_data,
  output logic [MODE_W-1:0]  cfg_mode,
  output logic [OFFS_W-1:0]  cfg_offset,
  output logic [PHASE_W-1:0] cfg_phase
);
  logic [RES_W-1:0]   res_q;
  logic [MODE_W-1:0]  mode_q;
  logic [OFFS_W-1:0]  offs_q;
  logic [PHASE_W-1:0] phase_q;

  always_comb begin
    rd_data = '0;
    rd_len  = LEN_W'(1);
    case (look_addr)
      A_RESULT: begin rd_data = res_q; rd_len = LEN_W'(RES_BYTES); end
      A_MODE:   begin rd_data = {mode_q,  {(RES_W-MODE_W){1'b0}}};  rd_len = LEN_W'(MODE_W/8);  end
      A_OFFSET: begin rd_data = {offs_q,  {(RES_W-OFFS_W){1'b0}}};  rd_len = LEN_W'(OFFS_W/8);  end
      A_PHASE:  begin rd_data = {phase_q, {(RES_W-PHASE_W){1'b0}}}; rd_len = LEN_W'(PHASE_W/8); end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      mode_q  <= '0;
      offs_q  <= '0;
      phase_q <= '0;
    end else begin
      if (conv_valid) res_q <= conv_data;
      if (wr_en) begin
        case (wr_addr)
          A_MODE:   mode_q  <= wr_data[MODE_W-1:0];
          A_OFFSET: offs_q  <= wr_data[OFFS_W-1:0];
          A_PHASE:  phase_q <= wr_data[PHASE_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  assign cfg_mode   = mode_q;
  assign cfg_offset = offs_q;
  assign cfg_phase  = phase_q;

  // R6: serial writes never reach the result register
  assert_result_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_RESULT && !conv_valid) |=> $stable(res_q));
  // R8: writes outside the map leave configuration untouched
  assert_unmapped_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != A_MODE && wr_addr != A_OFFSET && wr_addr != A_PHASE)
    |=> ($stable(mode_q) && $stable(offs_q) && $stable(phase_q)));
endmodule

// File: rtl/spirf_drdy.sv
module spirf_drdy (
  input  logic clk,
  input  logic rst_n,
  input  logic drdy_in,
  input  logic conv_valid,
  input  logic res_read,
  output logic drdy_out
);
  logic drdy_q, pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drdy_q <= 1'b1;
      pend_q <= 1'b0;
    end else if (drdy_in) begin
      drdy_q <= 1'b1;
      pend_q <= 1'b0;
    end else if (conv_valid) begin
      if (!drdy_q) begin
        drdy_q <= 1'b1;
        pend_q <= 1'b1;
      end else begin
        drdy_q <= 1'b0;
      end
    end else if (pend_q) begin
      drdy_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (res_read) begin
      drdy_q <= 1'b1;
    end
  end

  assign drdy_out = drdy_q;

  // R9: a new result pulls the flag low
  assert_flag_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!drdy_in && conv_valid && drdy_q) |=> !drdy_q);
  // R10: completed result read clears the flag
  assert_read_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_read && !conv_valid && !pend_q && !drdy_in) |=> drdy_q);
  // R11: re-arm pulse is a single cycle high followed by low
  assert_rearm_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!drdy_in && conv_valid && !drdy_q) |=> (drdy_q ##1 (drdy_in || !drdy_q)));
  // R12: gated while the input is high
  assert_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    drdy_in |=> drdy_q);
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
  import spirf_pkg::*;
#(
  parameter int CH_N = 4,
  parameter int CH_W = 24,
  parameter int SYNC_STAGES = 2,
  localparam int RES_W = CH_N * CH_W,
  localparam int RES_BYTES = RES_W / 8,
  localparam int LEN_W = $clog2(RES_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               din,
  output logic               dout,
  output logic               dout_oe,
  input  logic               drdy_in,
  output logic               drdy_out,
  input  logic               conv_valid,
  input  logic [RES_W-1:0]   conv_data,
  output logic [MODE_W-1:0]  cfg_mode,
  output logic [OFFS_W-1:0]  cfg_offset,
  output logic [PHASE_W-1:0] cfg_phase
);
  pins_t pins_raw, pins_s;
  logic [ADDR_W-1:0] look_addr, frm_addr;
  logic [RES_W-1:0]  rd_data, wr_data;
  logic [LEN_W-1:0]  rd_len;
  logic              wr_en, rd_fin, res_read;

  assign pins_raw = '{cs_n: cs_n, sclk: sclk, din: din};

  spirf_sync #(.STAGES(SYNC_STAGES), .W($bits(pins_t)), .INIT(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  spirf_frame #(.RES_W(RES_W), .ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_s(pins_s.cs_n), .sclk_s(pins_s.sclk), .din_s(pins_s.din),
    .look_addr(look_addr), .rd_data(rd_data), .rd_len(rd_len),
    .frm_addr(frm_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_fin(rd_fin), .dout(dout), .dout_oe(dout_oe)
  );

  spirf_regbank #(.CH_N(CH_N), .CH_W(CH_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .look_addr(look_addr), .rd_data(rd_data), .rd_len(rd_len),
    .wr_en(wr_en), .wr_addr(frm_addr), .wr_data(wr_data),
    .conv_valid(conv_valid), .conv_data(conv_data),
    .cfg_mode(cfg_mode), .cfg_offset(cfg_offset), .cfg_phase(cfg_phase)
  );

  assign res_read = rd_fin && (frm_addr == A_RESULT);

  spirf_drdy u_drdy (
    .clk(clk), .rst_n(rst_n), .drdy_in(drdy_in),
    .conv_valid(conv_valid), .res_read(res_read), .drdy_out(drdy_out)
  );
endmodule

// File: tb/sim_spi_regfile_slave.sv
module sim_spi_regfile_slave;
  localparam int H = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
  logic dout, dout_oe, drdy_out;
  logic drdy_in = 1'b0;
  logic conv_valid = 1'b0;
  logic [95:0] conv_data = '0;
  logic [7:0]  cfg_mode;
  logic [15:0] cfg_offset;
  logic [23:0] cfg_phase;

  int total = 0;
  int bad = 0;
  logic cmd_dout_or;
  logic oe_mid;

  always #10 clk = ~clk;

  spi_regfile_slave u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .drdy_in(drdy_in), .drdy_out(drdy_out),
    .conv_valid(conv_valid), .conv_data(conv_data),
    .cfg_mode(cfg_mode), .cfg_offset(cfg_offset), .cfg_phase(cfg_phase)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // cut < 0: full frame; no_last_rise: final rising edge withheld
  task automatic xfer(input logic [7:0] cmd, input int nbytes, input logic [95:0] wdat,
                      input int cut, input bit no_last_rise, output logic [95:0] rdat);
    int n;
    n = (cut >= 0) ? cut : 8 + 8 * nbytes;
    rdat = '0;
    cmd_dout_or = 1'b0;
    cs_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < n; i++) begin
      din = (i < 8) ? cmd[7-i] : wdat[8*nbytes-1-(i-8)];
      wait_clk(H);
      if (i >= 8) rdat = {rdat[94:0], dout};
      else        cmd_dout_or = cmd_dout_or | dout;
      sclk = 1'b0;
      wait_clk(H);
      if (!(no_last_rise && i == n-1)) sclk = 1'b1;
    end
    wait_clk(H);
    oe_mid = dout_oe;
    cs_n = 1'b1;
    wait_clk(H);
    sclk = 1'b1;
    wait_clk(2*H);
  endtask

  task automatic conv_beat(input logic [95:0] d);
    conv_data = d;
    conv_valid = 1'b1;
    @(negedge clk);
    conv_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [95:0] r;
    check("R13 oe", {95'd0, dout_oe}, 96'd0);
    check("R13 drdy", {95'd0, drdy_out}, 96'd1);
    check("R13 cfg", {48'd0, cfg_mode, cfg_offset, cfg_phase}, 96'd0);
    xfer(8'h80, 12, '0, -1, 0, r);
    check("R13 result", r, 96'd0);
  endtask

  task automatic t_write_read;
    logic [95:0] r;
    xfer(8'h01, 1, 96'hA5, -1, 0, r);
    check("R1 R5 mode port", {88'd0, cfg_mode}, 96'hA5);
    xfer(8'h02, 2, 96'hBEEF, -1, 0, r);
    check("R4 offset port", {80'd0, cfg_offset}, 96'hBEEF);
    xfer(8'h03, 3, 96'h9ABCDE, -1, 0, r);
    check("R4 phase port", {72'd0, cfg_phase}, 96'h9ABCDE);
    xfer(8'h81, 1, '0, -1, 0, r);
    check("R1 R2 mode read", r, 96'hA5);
    check("R2 cmd-phase dout", {95'd0, cmd_dout_or}, 96'd0);
    check("R3 oe in frame", {95'd0, oe_mid}, 96'd1);
    check("R3 oe after", {95'd0, dout_oe}, 96'd0);
    xfer(8'h82, 2, '0, -1, 0, r);
    check("R4 offset read", r, 96'hBEEF);
    xfer(8'h83, 3, '0, -1, 0, r);
    check("R4 phase read", r, 96'h9ABCDE);
  endtask

  task automatic t_abort;
    logic [95:0] r;
    xfer(8'h01, 1, 96'h3C, 12, 0, r);
    check("R5 mid abort", {88'd0, cfg_mode}, 96'hA5);
    xfer(8'h02, 2, 96'h1234, 24, 1, r);
    check("R5 no last rise", {80'd0, cfg_offset}, 96'hBEEF);
    xfer(8'h01, 1, 96'h5A, -1, 0, r);
    check("R5 full after abort", {88'd0, cfg_mode}, 96'h5A);
  endtask

  task automatic t_result;
    logic [95:0] r;
    logic [95:0] d1 = 96'h123456_ABCDEF_800001_7F00FF;
    drdy_in = 1'b0;
    conv_beat(d1);
    check("R9 drdy falls", {95'd0, drdy_out}, 96'd0);
    xfer(8'h80, 12, '0, -1, 0, r);
    check("R6 result read", r, d1);
    check("R10 drdy cleared", {95'd0, drdy_out}, 96'd1);
    xfer(8'h00, 12, {96{1'b1}}, -1, 0, r);
    xfer(8'h80, 12, '0, -1, 0, r);
    check("R6 result read-only", r, d1);
  endtask

  task automatic t_snapshot;
    logic [95:0] r;
    logic [95:0] d1 = 96'h123456_ABCDEF_800001_7F00FF;
    logic [95:0] d2 = 96'hFEDCBA_000000_FFFFFF_55AA55;
    fork
      xfer(8'h80, 12, '0, -1, 0, r);
      begin wait_clk(200); conv_beat(d2); end
    join
    check("R7 snapshot old", r, d1);
    xfer(8'h80, 12, '0, -1, 0, r);
    check("R7 next read new", r, d2);
  endtask

  task automatic t_unmapped;
    logic [95:0] r;
    xfer(8'hD5, 1, '0, -1, 0, r);
    check("R8 unmapped read", r, 96'd0);
    xfer(8'h7F, 1, 96'hFF, -1, 0, r);
    check("R8 unmapped write", {48'd0, cfg_mode, cfg_offset, cfg_phase},
          {48'd0, 8'h5A, 16'hBEEF, 24'h9ABCDE});
    xfer(8'h81, 1, '0, -1, 0, r);
    check("R4 R8 frame after unmapped", r, 96'h5A);
  endtask

  task automatic t_drdy;
    drdy_in = 1'b0;
    conv_beat(96'h1);
    check("R9 drdy low", {95'd0, drdy_out}, 96'd0);
    conv_beat(96'h2);
    check("R11 pulse high", {95'd0, drdy_out}, 96'd1);
    @(negedge clk);
    check("R11 low again", {95'd0, drdy_out}, 96'd0);
    drdy_in = 1'b1;
    wait_clk(2);
    check("R12 forced high", {95'd0, drdy_out}, 96'd1);
    conv_beat(96'h3);
    wait_clk(2);
    check("R12 gated conv", {95'd0, drdy_out}, 96'd1);
    drdy_in = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);
    t_reset();
    t_write_read();
    t_abort();
    t_result();
    t_snapshot();
    t_unmapped();
    t_drdy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule